// File: doc/BRIEF.md
# Dual-Channel Transmit Byte Queue

This block sits between a register-mapped processor port and a byte-wide frame output. Software places frame data in one of two byte queues, programs a length for that queue and issues a launch command. The block then streams that many bytes out on a valid/ready byte interface, marking the final byte of the frame. Both queues share one 32-bit data register, and a select register decides which queue receives each data word.

When a frame has gone out, the queue it came from is emptied and its length is cleared. A done flag for that queue is set in a shared status register. The status bits are masked by an enable register to form one interrupt line. Status bits are cleared by writing ones to them. A soft-reset bit in the control register returns both queues and all configuration to their idle state. Framing, checksums and the line interface are handled elsewhere.

The register word index is `wr_addr`/`rd_addr`. The map is: 0 control (bit 0 soft reset, bit 1 transmit enable), 1 mode, 2 queue select, 3 data, 4 length of queue 0, 5 length of queue 1, 6 launch queue 0, 7 launch queue 1, 8 interrupt enable, 9 interrupt status. Status/enable bit n belongs to queue n. Reads of the data register, the launch registers and unused indices return zero.

Top module: `dtx_fifo_ctrl`

## Requirements
- R1: A write to index 3 appends four bytes to the selected queue, taking bits 7:0 first and bits 31:24 last. When fewer than four bytes are free, the whole word is discarded.
- R2: A write to the select register stores the written value when it is 0 or 1, and stores 0 for any value of 2 or more. Read back returns the stored value.
- R3: A length write greater than the queue capacity `FIFO_BYTES` stores `FIFO_BYTES`; any other value is stored as written.
- R4: A launch write starts a frame only when its bit 0 is 1 and control bit 1 (transmit enable) is set.
- R5: A started frame carries min(programmed length, bytes held) bytes, oldest first. When that minimum is zero, nothing is sent and no state changes.
- R6: After the last byte of a frame is accepted, that queue holds no bytes, its length reads 0 and its status bit is set.
- R7: `irq` is high exactly when some status bit and its enable bit are both 1. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: A control write with bit 0 set empties both queues. It clears both lengths, the select, mode, enable and status registers, and aborts any frame in progress. The rest of the written value is stored with bit 0 reading back 0. The same idle values hold after `rst_n`.
- R9: Output bytes move when `tx_valid` and `tx_ready` are both high. `tx_data` and `tx_valid` hold while `tx_ready` is low, and `tx_last` marks the final byte. Only one frame is in flight at a time, and a launch arriving during a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word index |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 4 | Register read word index |
| rd_data | output | 32 | Register read value (combinational) |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Masked transmit-done interrupt |

## Verification
The hardest case to reach from the ports is a launch of the second queue while the first is still streaming. To create it, the stimulus holds `tx_ready` low after a launch, so the frame stalls mid-flight, and then writes the other launch register. It then checks that the stalled byte did not move and that the other queue's length, contents and status are untouched. The discard of a data word that does not fit is also reached on purpose, by writing more words than the queue can hold. Random rounds then mix select values above 1, oversized lengths, disabled transmit and random ready back-pressure against a queue model kept in the bench.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
   localparam int NCH = 2;

   typedef enum logic [3:0] {
      RG_CTRL  = 4'd0,
      RG_MODE  = 4'd1,
      RG_SEL   = 4'd2,
      RG_DATA  = 4'd3,
      RG_LEN0  = 4'd4,
      RG_LEN1  = 4'd5,
      RG_GO0   = 4'd6,
      RG_GO1   = 4'd7,
      RG_IEN   = 4'd8,
      RG_ISTAT = 4'd9
   } reg_idx_e;

   localparam int CTRL_SRST_BIT = 0;
   localparam int CTRL_TXEN_BIT = 1;
endpackage

// File: rtl/dtx_byte_fifo.sv
module dtx_byte_fifo #(
   parameter int DEPTH = 64,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [31:0]   push_word,
   input  logic          pop,
   output logic [7:0]    head,
   output logic [LW-1:0] count
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dtx_byte_fifo: DEPTH must be a power of two and at least 4");
   end
   if (LW != $clog2(DEPTH + 1)) begin : g_bad_lw
      $error("dtx_byte_fifo: LW does not match DEPTH");
   end

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [LW-1:0] cnt_q;
   logic          push_ok;

   assign push_ok = push && !flush && (cnt_q <= LW'(DEPTH - 4));
   assign head    = mem[rp_q];
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + PW'(4);
         if (pop)     rp_q <= rp_q + PW'(1);
         cnt_q <= cnt_q + (push_ok ? LW'(4) : LW'(0)) - (pop ? LW'(1) : LW'(0));
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         for (int i = 0; i < 4; i++) begin
            mem[wp_q + PW'(i)] <= push_word[8*i +: 8];
         end
      end
   end

   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LW'(DEPTH));

   assert_drop_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && cnt_q > LW'(DEPTH - 4))
      |=> cnt_q == $past(cnt_q) - ($past(pop) ? LW'(1) : LW'(0)));

   assert_push_adds_four_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && !pop && cnt_q <= LW'(DEPTH - 4))
      |=> cnt_q == $past(cnt_q) + LW'(4));
endmodule

// File: rtl/dtx_launcher.sv
module dtx_launcher #(
   parameter int LW = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                abort,
   input  logic [1:0]          go,
   input  logic [1:0][LW-1:0]  len,
   input  logic [1:0][LW-1:0]  cnt,
   input  logic [1:0][7:0]     head,
   input  logic                tx_ready,
   output logic                tx_valid,
   output logic [7:0]          tx_data,
   output logic                tx_last,
   output logic [1:0]          pop,
   output logic [1:0]          done
);
   logic [1:0][LW-1:0] eff;
   logic [1:0]         can_go;
   logic               busy_q;
   logic               ch_q;
   logic [LW-1:0]      rem_q;
   logic               start, start_ch, xfer;

   for (genvar c = 0; c < 2; c++) begin : g_ch
      assign eff[c]    = (len[c] < cnt[c]) ? len[c] : cnt[c];
      assign can_go[c] = go[c] && (eff[c] != '0);
      assign pop[c]    = xfer && (ch_q == 1'(c));
      assign done[c]   = pop[c] && (rem_q == LW'(1));
   end

   assign start    = !busy_q && (|can_go);
   assign start_ch = can_go[0] ? 1'b0 : 1'b1;
   assign xfer     = busy_q && tx_ready;
   assign tx_valid = busy_q;
   assign tx_data  = head[ch_q];
   assign tx_last  = busy_q && (rem_q == LW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ch_q   <= 1'b0;
         rem_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         ch_q   <= 1'b0;
         rem_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         ch_q   <= start_ch;
         rem_q  <= eff[start_ch];
      end else if (xfer) begin
         rem_q <= rem_q - LW'(1);
         if (rem_q == LW'(1)) busy_q <= 1'b0;
      end
   end

   assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n || abort)
      (busy_q && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   assert_busy_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> rem_q != '0);

   assert_go_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n || abort)
      (busy_q && (|go) && !(|done))
      |=> busy_q && $stable(ch_q) && rem_q == $past(rem_q) - ($past(xfer) ? LW'(1) : LW'(0)));
endmodule

// File: rtl/dtx_fifo_ctrl.sv
module dtx_fifo_ctrl
   import dtx_pkg::*;
#(
   parameter int FIFO_BYTES = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [3:0]  rd_addr,
   output logic [31:0] rd_data,
   output logic [7:0]  tx_data,
   output logic        tx_valid,
   output logic        tx_last,
   input  logic        tx_ready,
   output logic        irq
);
   localparam int LW = $clog2(FIFO_BYTES + 1);

   logic [31:0]         ctrl_q, mode_q;
   logic                sel_q;
   logic [1:0][LW-1:0]  len_q;
   logic [1:0]          ien_q, ist_q;
   logic [1:0][LW-1:0]  cnt;
   logic [1:0][7:0]     head;
   logic [1:0]          go, pop, done, push, flush;
   logic                srst;
   logic [LW-1:0]       len_wval;

   assign srst     = wr_en && (wr_addr == RG_CTRL) && wr_data[CTRL_SRST_BIT];
   assign len_wval = (wr_data > 32'(FIFO_BYTES)) ? LW'(FIFO_BYTES) : wr_data[LW-1:0];

   for (genvar c = 0; c < NCH; c++) begin : g_q
      assign push[c]  = wr_en && (wr_addr == RG_DATA) && (sel_q == 1'(c));
      assign flush[c] = srst || done[c];
      assign go[c]    = wr_en && (wr_addr == 4'(RG_GO0 + c)) && wr_data[0]
                        && ctrl_q[CTRL_TXEN_BIT];

      dtx_byte_fifo #(.DEPTH(FIFO_BYTES), .LW(LW)) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush[c]),
         .push      (push[c]),
         .push_word (wr_data),
         .pop       (pop[c]),
         .head      (head[c]),
         .count     (cnt[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                            len_q[c] <= '0;
         else if (srst)                                         len_q[c] <= '0;
         else if (wr_en && wr_addr == 4'(RG_LEN0 + c))          len_q[c] <= len_wval;
         else if (done[c])                                      len_q[c] <= '0;
      end

      assert_len_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
         len_q[c] <= LW'(FIFO_BYTES));

      assert_done_flags_R6: assert property (@(posedge clk) disable iff (!rst_n || srst)
         done[c] |=> ist_q[c] && cnt[c] == '0);
   end

   dtx_launcher #(.LW(LW)) u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort    (srst),
      .go       (go),
      .len      (len_q),
      .cnt      (cnt),
      .head     (head),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_last  (tx_last),
      .pop      (pop),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
         sel_q  <= 1'b0;
         ien_q  <= '0;
         ist_q  <= '0;
      end else if (srst) begin
         ctrl_q <= wr_data & ~(32'd1 << CTRL_SRST_BIT);
         mode_q <= '0;
         sel_q  <= 1'b0;
         ien_q  <= '0;
         ist_q  <= '0;
      end else begin
         if (wr_en && wr_addr == RG_CTRL) ctrl_q <= wr_data;
         if (wr_en && wr_addr == RG_MODE) mode_q <= wr_data;
         if (wr_en && wr_addr == RG_SEL)  sel_q  <= (wr_data < 32'd2) ? wr_data[0] : 1'b0;
         if (wr_en && wr_addr == RG_IEN)  ien_q  <= wr_data[1:0];
         ist_q <= (ist_q & ~((wr_en && wr_addr == RG_ISTAT) ? wr_data[1:0] : 2'b00)) | done;
      end
   end

   assign irq = |(ist_q & ien_q);

   always_comb begin
      case (rd_addr)
         RG_CTRL:  rd_data = ctrl_q;
         RG_MODE:  rd_data = mode_q;
         RG_SEL:   rd_data = {31'd0, sel_q};
         RG_LEN0:  rd_data = 32'(len_q[0]);
         RG_LEN1:  rd_data = 32'(len_q[1]);
         RG_IEN:   rd_data = {30'd0, ien_q};
         RG_ISTAT: rd_data = {30'd0, ist_q};
         default:  rd_data = '0;
      endcase
   end

   assert_sel_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RG_SEL && wr_data >= 32'd2) |=> sel_q == 1'b0);

   assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ist_q == '0 && ien_q == '0 && !sel_q && !tx_valid && mode_q == '0));

   assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (wr_en && wr_addr == RG_ISTAT && done == '0)
      |=> (ist_q & $past(wr_data[1:0])) == 2'b00);

   assert_no_start_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_valid && !ctrl_q[CTRL_TXEN_BIT]) |=> !tx_valid);
endmodule

// File: tb/dtx_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
module dtx_fifo_ctrl_tb_top;
   localparam int DEPTH = 64;
   localparam logic [3:0] A_CTRL = 4'd0, A_MODE = 4'd1, A_SEL = 4'd2, A_DATA = 4'd3,
                          A_LEN0 = 4'd4, A_GO0 = 4'd6, A_IEN = 4'd8, A_IST = 4'd9;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_last;
   logic        tx_ready = 1'b0;
   logic        irq;

   dtx_fifo_ctrl #(.FIFO_BYTES(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [31:0] m_ctrl, m_mode;
   logic        m_sel;
   int          m_len [2];
   logic [1:0]  m_en, m_st;
   logic [7:0]  mq0 [$];
   logic [7:0]  mq1 [$];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int clamp_len(input logic [31:0] v);
      return (v > 32'(DEPTH)) ? DEPTH : int'(v);
   endfunction

   function automatic int q_size(input int ch);
      return (ch == 0) ? mq0.size() : mq1.size();
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic model_reset();
      mq0.delete(); mq1.delete();
      m_len[0] = 0; m_len[1] = 0;
      m_sel = 1'b0; m_mode = '0; m_en = '0; m_st = '0;
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      case (a)
         A_CTRL: begin
            if (d[0]) model_reset();
            m_ctrl = d & ~32'd1;
         end
         A_MODE: m_mode = d;
         A_SEL:  m_sel = (d < 32'd2) ? d[0] : 1'b0;
         A_DATA: begin
            if (q_size(int'(m_sel)) <= DEPTH - 4) begin
               for (int i = 0; i < 4; i++) begin
                  if (m_sel == 1'b0) mq0.push_back(d[8*i +: 8]);
                  else               mq1.push_back(d[8*i +: 8]);
               end
            end
         end
         A_LEN0:      m_len[0] = clamp_len(d);
         A_LEN0 + 1:  m_len[1] = clamp_len(d);
         A_IEN:       m_en = d[1:0];
         A_IST:       m_st = m_st & ~d[1:0];
         default: ;
      endcase
      wr(a, d);
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      rd_addr = a;
      #1;
      check(rd_data == exp, req, rd_data, exp);
   endtask

   task automatic irq_chk(input string req);
      @(negedge clk);
      check(irq == |(m_st & m_en), req, 32'(irq), 32'(|(m_st & m_en)));
   endtask

   task automatic collect(input logic [7:0] expf [$], input int n, input int ch,
                          input bit randready);
      int got = 0;
      int guard = 0;
      bit ok = 1'b1;
      logic [31:0] bad_act = '0, bad_exp = '0;
      while (got < n && guard < 5000) begin
         @(negedge clk);
         guard++;
         tx_ready = randready ? (($urandom % 4) != 0) : 1'b1;
         if (tx_valid && tx_ready) begin
            if (ok && (tx_data != expf[got] || tx_last != (got == n - 1))) begin
               ok = 1'b0;
               bad_act = {23'd0, tx_last, tx_data};
               bad_exp = {23'd0, (got == n - 1), expf[got]};
            end
            got++;
         end
      end
      check(ok && got == n, "R5/R9 frame bytes and last flag", bad_act, bad_exp);
      @(negedge clk);
      tx_ready = 1'b0;
      if (ch == 0) mq0.delete(); else mq1.delete();
      m_len[ch] = 0;
      m_st[ch]  = 1'b1;
      check(!tx_valid, "R9 idle after frame", 32'(tx_valid), 32'd0);
      rd_chk(A_LEN0 + 4'(ch), 32'd0, "R6 length cleared");
      rd_chk(A_IST, {30'd0, m_st}, "R6 status set");
      irq_chk("R7 irq after frame");
   endtask

   task automatic go(input int ch, input logic [31:0] d, input bit randready);
      int n;
      logic [7:0] expf [$];
      n = (m_ctrl[1] && d[0]) ? ((m_len[ch] < q_size(ch)) ? m_len[ch] : q_size(ch)) : 0;
      expf = (ch == 0) ? mq0 : mq1;
      wr(A_GO0 + 4'(ch), d);
      if (n == 0) begin
         bit quiet = 1'b1;
         repeat (3) begin
            @(negedge clk);
            if (tx_valid) quiet = 1'b0;
         end
         check(quiet, "R4/R5 no frame launched", 32'(!quiet), 32'd0);
         rd_chk(A_IST, {30'd0, m_st}, "R5 status untouched");
      end else begin
         collect(expf, n, ch, randready);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      m_ctrl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: idle values after reset
      rd_chk(A_CTRL, 32'd0, "R8 ctrl reset");
      rd_chk(A_SEL, 32'd0, "R8 sel reset");
      rd_chk(A_LEN0, 32'd0, "R8 len reset");
      rd_chk(A_IST, 32'd0, "R8 status reset");
      check(!tx_valid && !irq, "R8 outputs idle", {30'd0, tx_valid, irq}, 32'd0);

      reg_wr(A_CTRL, 32'h2);
      rd_chk(A_CTRL, 32'h2, "R8 ctrl stored");

      // R1: byte order, R5: shorter length
      reg_wr(A_SEL, 32'd0);
      reg_wr(A_DATA, 32'h44332211);
      reg_wr(A_DATA, 32'h88776655);
      reg_wr(A_LEN0, 32'd6);
      go(0, 32'd1, 1'b0);
      reg_wr(A_LEN0, 32'd4);
      go(0, 32'd1, 1'b0); // R6 queue emptied: nothing left to send

      // R2: select folding
      reg_wr(A_SEL, 32'd3);
      rd_chk(A_SEL, 32'd0, "R2 select 3 folds to 0");
      reg_wr(A_SEL, 32'd1);
      rd_chk(A_SEL, 32'd1, "R2 select 1 stored");
      reg_wr(A_SEL, 32'd2);
      rd_chk(A_SEL, 32'd0, "R2 select 2 folds to 0");

      // R3: length clamp
      reg_wr(A_LEN0, 32'd1000);
      rd_chk(A_LEN0, 32'(DEPTH), "R3 oversize length clamped");
      reg_wr(A_LEN0 + 4'd1, 32'(DEPTH));
      rd_chk(A_LEN0 + 4'd1, 32'(DEPTH), "R3 capacity length kept");
      reg_wr(A_LEN0 + 4'd1, 32'd0);

      // R1: overflow discards whole word
      for (int i = 0; i < 17; i++) reg_wr(A_DATA, $urandom);
      check(mq0.size() == DEPTH, "R1 model fill", 32'(mq0.size()), 32'(DEPTH));
      go(0, 32'd1, 1'b1);

      // R4: enable and bit 0 gating
      reg_wr(A_DATA, 32'hA5A5_0102);
      reg_wr(A_LEN0, 32'd4);
      reg_wr(A_CTRL, 32'h0);
      go(0, 32'd1, 1'b0);
      reg_wr(A_CTRL, 32'h2);
      go(0, 32'd0, 1'b0);
      go(0, 32'd1, 1'b0);

      // R7: masking and write-one-to-clear
      irq_chk("R7 masked");
      reg_wr(A_IEN, 32'd1);
      irq_chk("R7 enabled");
      reg_wr(A_IST, 32'd2);
      rd_chk(A_IST, {30'd0, m_st}, "R7 write 1 to other bit");
      irq_chk("R7 still pending");
      reg_wr(A_IST, 32'd1);
      rd_chk(A_IST, 32'd0, "R7 cleared");
      irq_chk("R7 deasserted");

      // R9: launch of other queue while stalled frame in flight
      reg_wr(A_DATA, 32'h0d0c0b0a);
      reg_wr(A_DATA, 32'h1d1c1b1a);
      reg_wr(A_LEN0, 32'd8);
      reg_wr(A_SEL, 32'd1);
      reg_wr(A_DATA, 32'hf3f2f1f0);
      reg_wr(A_LEN0 + 4'd1, 32'd4);
      begin
         logic [7:0] exp0 [$];
         exp0 = mq0;
         tx_ready = 1'b0;
         wr(A_GO0, 32'd1);
         wr(A_GO0 + 4'd1, 32'd1);
         @(negedge clk);
         check(tx_valid && tx_data == 8'h0a, "R9 stalled byte held",
               {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'h0a});
         rd_chk(A_LEN0 + 4'd1, 32'd4, "R9 other length untouched");
         collect(exp0, 8, 0, 1'b1);
      end
      rd_chk(A_IST, 32'd1, "R9 other status untouched");
      go(1, 32'd1, 1'b1);

      // R8: soft reset
      reg_wr(A_MODE, 32'h1234_5678);
      rd_chk(A_MODE, 32'h1234_5678, "R8 mode stored");
      reg_wr(A_IEN, 32'd3);
      reg_wr(A_DATA, 32'h11111111);
      reg_wr(A_SEL, 32'd0);
      reg_wr(A_DATA, 32'h22222222);
      reg_wr(A_LEN0, 32'd4);
      reg_wr(A_CTRL, 32'h3);
      rd_chk(A_CTRL, 32'h2, "R8 reset bit reads 0");
      rd_chk(A_MODE, 32'd0, "R8 mode cleared");
      rd_chk(A_IEN, 32'd0, "R8 enable cleared");
      rd_chk(A_IST, 32'd0, "R8 status cleared");
      rd_chk(A_LEN0, 32'd0, "R8 length cleared");
      irq_chk("R8 irq low");
      reg_wr(A_LEN0, 32'd4);
      go(0, 32'd1, 1'b0);
      reg_wr(A_LEN0 + 4'd1, 32'd4);
      go(1, 32'd1, 1'b0);

      // random rounds
      for (int r = 0; r < 40; r++) begin
         int ch = $urandom % 2;
         int nw = $urandom % 19;
         reg_wr(A_SEL, $urandom % 4);
         for (int k = 0; k < nw; k++) reg_wr(A_DATA, $urandom);
         reg_wr(A_LEN0 + 4'(ch), (($urandom % 8) == 0) ? 32'hFFFF_FFFF : ($urandom % 80));
         if (($urandom % 10) == 0) reg_wr(A_CTRL, 32'h0);
         if (($urandom % 3) == 0) reg_wr(A_IEN, $urandom % 4);
         go(ch, 32'd1, 1'b1);
         if (m_ctrl[1] == 1'b0) reg_wr(A_CTRL, 32'h2);
         if (($urandom % 4) == 0) begin
            reg_wr(A_IST, $urandom % 4);
            rd_chk(A_IST, {30'd0, m_st}, "R7 random clear");
         end
         irq_chk("R7 random irq");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule